// File: doc/BRIEF.md
# Relocatable System Configuration Controller

This block keeps a single system configuration word on a simple synchronous bus and decodes a 64 KB peripheral window whose base address is taken from a field of that same word. Because the word itself lives inside the window it moves, a write to the base field shifts the location of the configuration word for every later transaction. The transaction doing the write still completes at the old location.

Besides the window decode, the word drives four static controls: a cache enable, a write-buffer enable, a stall enable and a two-bit mode that splits a 4 KB internal memory between cache and SRAM. With stall enabled, the block holds its ready output low for exactly one cycle on every non-sequential access. Ready is combinational in the cycle a request is presented, so a request is held until ready is seen high. The write commits on the clock edge of that cycle.

Top module: `sysconf_ctrl`

## Requirements
- R1: After reset the word reads 0x0000FFF1: `stall_en`=1, `cache_en`=0, `wbuf_en`=0, base field 0x7FF (window base 0x07FF0000) and `mem_mode`=01.
- R2: `hit` is 1 exactly when `req` is 1 and `addr[31:16]` equals the 11-bit base field zero-extended to 16 bits, i.e. the address lies in the 64 KB span beginning at base<<16.
- R3: The word is read and written at window base + 0x1000. Its readback layout is: bit 0 stall enable, bit 1 cache enable, bit 2 write-buffer enable, bit 3 zero, bits 14:4 base field, bits 16:15 mode, bits 31:17 zero. A read at any other address returns 0.
- R4: A write that changes the base field completes at the old address. From the next transaction on, only the new base+0x1000 selects the word.
- R5: A write whose bits 16:15 are 11 leaves the mode unchanged, while the rest of the written fields still update. Mode 00 means 2 KB cache plus 2 KB SRAM, 01 means 4 KB cache and 10 means 4 KB SRAM. `mem_mode` never shows 11.
- R6: Written values in bit 3 and bits 31:17 have no effect, and those bits read 0.
- R7: With stall enabled, a non-sequential access sees `ready` low for exactly one cycle and high in the next. An access is non-sequential when no transfer completed in the previous cycle or when its address is not the previous transfer address plus 4. A sequential access sees `ready` in its first cycle.
- R8: With stall disabled, every request sees `ready` high in its first cycle.
- R9: `ready` is never high without `req`. `cache_en`, `wbuf_en`, `stall_en` and `mem_mode` follow the stored word from the cycle after the write.
- R10: A write to any address other than the configuration word leaves the word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, held until ready |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 32 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while ready is high |
| ready | output | 1 | Transfer completes at the next clock edge |
| hit | output | 1 | Address lies inside the window |
| cache_en | output | 1 | Cache enable |
| wbuf_en | output | 1 | Write-buffer enable |
| stall_en | output | 1 | Stall insertion enabled |
| mem_mode | output | 2 | Internal memory split |

## Verification
The base field is swept over all 2048 values. Each new value is written at the previous location and then probed at the new word address, at the last word of the new window, at the first byte past it and at the old word address. Together these probes separate an off-by-one window edge and a relocation applied too early from a correct design. Stall behaviour is tried with back-to-back +4 strides, with a +8 stride, with a repeated address and with a restart after idle, which separates the sequence rule from plain wait insertion. All four mode codes and writes of reserved and upper bits show that illegal or dead fields are masked.

// File: rtl/sysconf_pkg.sv
package sysconf_pkg;

    localparam int DATA_W   = 32;
    localparam int BASE_W   = 11;
    localparam int BASE_LSB = 4;
    localparam int MODE_LSB = 15;

    localparam logic [1:0] MODE_SPLIT    = 2'b00;
    localparam logic [1:0] MODE_ALLCACHE = 2'b01;
    localparam logic [1:0] MODE_ALLSRAM  = 2'b10;
    localparam logic [1:0] MODE_UNUSED   = 2'b11;

    typedef struct packed {
        logic              stall;
        logic              cache;
        logic              wbuf;
        logic [BASE_W-1:0] base;
        logic [1:0]        mode;
    } cfg_t;

    function automatic cfg_t cfg_reset();
        cfg_t c;
        c.stall = 1'b1;
        c.cache = 1'b0;
        c.wbuf  = 1'b0;
        c.base  = '1;
        c.mode  = MODE_ALLCACHE;
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] cfg_pack(cfg_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[0] = c.stall;
        w[1] = c.cache;
        w[2] = c.wbuf;
        w[BASE_LSB +: BASE_W] = c.base;
        w[MODE_LSB +: 2] = c.mode;
        return w;
    endfunction

    function automatic cfg_t cfg_merge(cfg_t old, logic [DATA_W-1:0] w);
        cfg_t c;
        c.stall = w[0];
        c.cache = w[1];
        c.wbuf  = w[2];
        c.base  = w[BASE_LSB +: BASE_W];
        c.mode  = (w[MODE_LSB +: 2] == MODE_UNUSED) ? old.mode : w[MODE_LSB +: 2];
        return c;
    endfunction

endpackage

// File: rtl/sysconf_regfile.sv
module sysconf_regfile
    import sysconf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output cfg_t              cfg_q
);

    cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            cfg_d = cfg_merge(cfg_q, wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= cfg_reset();
        end else begin
            cfg_q <= cfg_d;
        end
    end

endmodule

// File: rtl/sysconf_decode.sv
module sysconf_decode
    import sysconf_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          WIN_SHIFT = 16,
    parameter int unsigned REG_OFS   = 32'h1000
) (
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BASE_W-1:0] base,
    output logic              hit,
    output logic              sel
);

    localparam int HI_W = ADDR_W - WIN_SHIFT;

    logic [HI_W-1:0]      win_hi;
    logic [WIN_SHIFT-1:0] ofs;

    always_comb begin
        win_hi = HI_W'(base);
        ofs    = addr[WIN_SHIFT-1:0];
        hit    = req && (addr[ADDR_W-1:WIN_SHIFT] == win_hi);
        sel    = hit && (ofs == WIN_SHIFT'(REG_OFS));
    end

endmodule

// File: rtl/sysconf_stall.sv
module sysconf_stall #(
    parameter int ADDR_W = 32,
    parameter int STRIDE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic              stall_en,
    output logic              ready
);

    typedef struct packed {
        logic [ADDR_W-1:0] last_addr;
        logic              last_valid;
        logic              waited;
    } seq_t;

    seq_t st_d, st_q;
    logic is_seq;

    always_comb begin
        is_seq = st_q.last_valid && (addr == st_q.last_addr + ADDR_W'(STRIDE));
        ready  = req && (!stall_en || is_seq || st_q.waited);

        st_d            = st_q;
        st_d.last_valid = req && ready;
        st_d.waited     = req && !ready;
        if (req && ready) begin
            st_d.last_addr = addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sysconf_ctrl.sv
module sysconf_ctrl
    import sysconf_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          WIN_SHIFT = 16,
    parameter int unsigned REG_OFS   = 32'h1000,
    parameter int          STRIDE    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              ready,
    output logic              hit,
    output logic              cache_en,
    output logic              wbuf_en,
    output logic              stall_en,
    output logic [1:0]        mem_mode
);

    cfg_t cfg_q;
    logic sel;
    logic wr_en;

    sysconf_decode #(
        .ADDR_W   (ADDR_W),
        .WIN_SHIFT(WIN_SHIFT),
        .REG_OFS  (REG_OFS)
    ) u_decode (
        .req (req),
        .addr(addr),
        .base(cfg_q.base),
        .hit (hit),
        .sel (sel)
    );

    sysconf_stall #(
        .ADDR_W(ADDR_W),
        .STRIDE(STRIDE)
    ) u_stall (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .addr    (addr),
        .stall_en(cfg_q.stall),
        .ready   (ready)
    );

    sysconf_regfile u_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(wr_en),
        .wdata(wdata),
        .cfg_q(cfg_q)
    );

    always_comb begin
        wr_en    = sel && we && ready;
        rdata    = (sel && !we) ? cfg_pack(cfg_q) : '0;
        cache_en = cfg_q.cache;
        wbuf_en  = cfg_q.wbuf;
        stall_en = cfg_q.stall;
        mem_mode = cfg_q.mode;
    end

endmodule

// File: rtl/sysconf_ctrl_chk.sv
module sysconf_ctrl_chk #(
    parameter int          ADDR_W    = 32,
    parameter int          WIN_SHIFT = 16,
    parameter int unsigned REG_OFS   = 32'h1000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       rdata,
    input logic              ready,
    input logic              hit,
    input logic              cache_en,
    input logic              wbuf_en,
    input logic              stall_en,
    input logic [1:0]        mem_mode
);

    logic at_word;
    assign at_word = hit && (addr[WIN_SHIFT-1:0] == WIN_SHIFT'(REG_OFS));

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (stall_en && !cache_en && !wbuf_en && mem_mode == 2'b01));

    assert_ready_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> req);

    assert_mode_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_mode != 2'b11);

    assert_no_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !stall_en) |-> ready);

    assert_single_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ready) |=> (!req || ready));

    assert_dead_bits_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !we && at_word) |-> (rdata[3] == 1'b0 && rdata[31:17] == 15'd0));

    assert_other_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !at_word) |-> (rdata == 32'd0));

endmodule

bind sysconf_ctrl sysconf_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .WIN_SHIFT(WIN_SHIFT),
    .REG_OFS  (REG_OFS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .we      (we),
    .addr    (addr),
    .rdata   (rdata),
    .ready   (ready),
    .hit     (hit),
    .cache_en(cache_en),
    .wbuf_en (wbuf_en),
    .stall_en(stall_en),
    .mem_mode(mem_mode)
);

// File: tb/test_sysconf_ctrl.sv
`timescale 1ns/100ps
module test_sysconf_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [31:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ready, hit, cache_en, wbuf_en, stall_en;
    logic [1:0]  mem_mode;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sysconf_ctrl i_sysconf_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ready(ready), .hit(hit), .cache_en(cache_en),
        .wbuf_en(wbuf_en), .stall_en(stall_en), .mem_mode(mem_mode)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // Called just after a falling edge; leaves req high just after the next falling edge.
    task automatic access(input logic [31:0] a, input bit w, input logic [31:0] d,
                          output logic [31:0] rd, output int waits);
        req = 1'b1; we = w; addr = a; wdata = d;
        waits = 0;
        #1;
        while (!ready && waits < 4) begin
            @(negedge clk); #1;
            waits++;
        end
        rd = rdata;
        @(negedge clk);
    endtask

    task automatic idle();
        req = 1'b0; we = 1'b0;
        @(negedge clk);
    endtask

    // Samples hit for an address, then completes the read and returns data.
    task automatic probe(input logic [31:0] a, output bit h, output logic [31:0] rd);
        int w;
        req = 1'b1; we = 1'b0; addr = a;
        #1; h = hit;
        access(a, 1'b0, 32'd0, rd, w);
    endtask

    function automatic logic [31:0] word(input bit s, input bit c, input bit b,
                                         input logic [10:0] base, input logic [1:0] m);
        return {15'd0, m, base, 1'b0, b, c, s};
    endfunction

    initial begin
        logic [31:0] rd;
        int          w;
        bit          h;
        logic [31:0] base_addr;
        logic [31:0] a0;
        logic [1:0]  cur_mode;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(stall_en == 1'b1 && cache_en == 1'b0 && wbuf_en == 1'b0,
              "R1 enables", {29'd0, wbuf_en, cache_en, stall_en}, 32'h1);
        check(mem_mode == 2'b01, "R1 mode", {30'd0, mem_mode}, 32'h1);
        access(32'h07FF1000, 1'b0, 0, rd, w);
        check(rd == 32'h0000FFF1, "R1 reset readback", rd, 32'h0000FFF1);
        check(w == 1, "R7 wait after idle", w, 1);
        idle();

        // R7 stall sequence rules (stall enabled at reset)
        a0 = 32'h07FF0100;
        access(a0, 1'b0, 0, rd, w);
        check(w == 1, "R7 first after idle", w, 1);
        check(rd == 0, "R3 non-word read zero", rd, 0);
        access(a0 + 4, 1'b0, 0, rd, w);
        check(w == 0, "R7 stride +4 no wait", w, 0);
        access(a0 + 8, 1'b0, 0, rd, w);
        check(w == 0, "R7 stride +4 again", w, 0);
        access(a0 + 16, 1'b0, 0, rd, w);
        check(w == 1, "R7 stride +8 waits", w, 1);
        access(a0 + 16, 1'b0, 0, rd, w);
        check(w == 1, "R7 repeated addr waits", w, 1);
        access(a0 + 20, 1'b0, 0, rd, w);
        check(w == 0, "R7 after stalled access +4", w, 0);
        idle();
        access(a0 + 24, 1'b0, 0, rd, w);
        check(w == 1, "R7 +4 after idle waits", w, 1);
        idle();

        // R9 / R8 turn stall off, cache and write buffer on
        access(32'h07FF1000, 1'b1, word(0, 1, 1, 11'h7FF, 2'b01), rd, w);
        idle();
        check(stall_en == 0 && cache_en == 1 && wbuf_en == 1, "R9 enables follow word",
              {29'd0, wbuf_en, cache_en, stall_en}, 32'h6);
        check(ready == 0, "R9 ready without req", ready, 0);
        access(32'h00001234, 1'b0, 0, rd, w);
        check(w == 0, "R8 no wait, non-seq", w, 0);
        access(32'h00009000, 1'b0, 0, rd, w);
        check(w == 0, "R8 no wait, jump", w, 0);
        idle();

        // R5 mode sweep
        cur_mode = 2'b01;
        for (int m = 0; m < 4; m++) begin
            access(32'h07FF1000, 1'b1, word(0, m[0], 1, 11'h7FF, 2'(m)), rd, w);
            if (m != 3) cur_mode = 2'(m);
            access(32'h07FF1000, 1'b0, 0, rd, w);
            check(mem_mode == cur_mode, "R5 mode output", mem_mode, cur_mode);
            check(rd == word(0, m[0], 1, 11'h7FF, cur_mode), "R5 readback",
                  rd, word(0, m[0], 1, 11'h7FF, cur_mode));
        end
        idle();

        // R6 reserved and upper bits
        access(32'h07FF1000, 1'b1, word(0, 1, 0, 11'h7FF, 2'b10) | 32'hFFFE0008, rd, w);
        access(32'h07FF1000, 1'b0, 0, rd, w);
        check(rd == word(0, 1, 0, 11'h7FF, 2'b10), "R6 dead bits ignored",
              rd, word(0, 1, 0, 11'h7FF, 2'b10));
        // R10 write elsewhere in and out of window
        access(32'h07FF1004, 1'b1, 32'h0, rd, w);
        access(32'h07FF0000, 1'b1, 32'h0, rd, w);
        access(32'h12340000, 1'b1, 32'h0, rd, w);
        access(32'h07FF1000, 1'b0, 0, rd, w);
        check(rd == word(0, 1, 0, 11'h7FF, 2'b10), "R10 other writes ignored",
              rd, word(0, 1, 0, 11'h7FF, 2'b10));
        idle();

        // R2 / R3 / R4 base sweep over all field values
        base_addr = 32'h07FF0000;
        for (int b = 0; b < 2048; b++) begin
            logic [31:0] nb;
            logic [31:0] exp;
            nb  = 32'(b) << 16;
            exp = word(0, 1, 0, 11'(b), 2'b10);
            access(base_addr + 32'h1000, 1'b1, exp, rd, w);
            probe(nb + 32'h1000, h, rd);
            check(h == 1'b1, "R2 hit at new word", h, 1);
            check(rd == exp, "R4 word at new base", rd, exp);
            probe(nb + 32'hFFFC, h, rd);
            check(h == 1'b1, "R2 hit at window top", h, 1);
            probe(nb + 32'h10000, h, rd);
            check(h == 1'b0, "R2 miss past window", h, 0);
            if (nb != base_addr) begin
                probe(base_addr + 32'h1000, h, rd);
                check(h == 1'b0 && rd == 0, "R4 old address released", rd, 0);
            end
            base_addr = nb;
            idle();
        end
        // R2 just below window
        probe(base_addr - 1, h, rd);
        check(h == 1'b0, "R2 miss below window", h, 0);
        idle();

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule